// File: doc/BRIEF.md
# NAND Page Program Sequencer

This block is the host-side engine that writes one page of an external NAND-style flash device. A client hands it a request: the row to program, the column where loading starts, a byte count and a choice of completion method. The data then follows on a separate valid/ready stream. The sequencer drives the device's command, address and data bus cycles. It issues the program confirm, waits for the device to finish and returns a single-cycle done pulse with a pass/fail flag.

A byte on the data stream may carry a jump flag and a new column. The sequencer then inserts a column-change command with two column address cycles before that byte. This lets one page load cover several non-contiguous column ranges. Completion is found in one of two ways: by watching the ready/busy line, or by polling the status register at a fixed interval. A busy period longer than a set limit makes the sequencer reset the device and report failure.

Top module: `nand_prog_seq`

## Requirements
- R1: An accepted request drives, in order, command 0x80, five address cycles (column bits 7:0, column bits 15:8, row bits 7:0, row bits 15:8, row bits 23:16), the data bytes in stream order, then command 0x10.
- R2: A data byte whose jump flag is set, other than the first byte of the request, is preceded by command 0x85 and two address cycles (new column bits 7:0, then bits 15:8). Command 0x80 is not repeated. A jump flag on the first byte has no effect on the bus sequence.
- R3: A request with a byte count of 0 or above MAX_BYTES (default 2112) is answered with done and fail high in the cycle after acceptance, and chip enable stays high throughout.
- R4: With the poll select input low, after 0x10 the sequencer waits for the ready/busy input to be high, then issues command 0x70 and exactly one status read.
- R5: With the poll select input high, after 0x10 the sequencer issues command 0x70 once, then reads status repeatedly, POLL_GAP cycles apart, until status bit 6 is 1.
- R6: On completion, the fail output equals status bit 0 of the final status read (0 = pass, 1 = fail).
- R7: If busy lasts longer than BUSY_LIMIT cycles after the confirm cycle, the sequencer issues command 0xFF and finishes with fail high. No further status read follows.
- R8: Request-ready goes low in the cycle after acceptance and stays low through the done pulse. It rises again only in the cycle after done. Done lasts one cycle.
- R9: Each bus cycle holds its strobe (write strobe for command, address and data; read strobe for status) low for PH_CYC clocks and then high for PH_CYC clocks. The command latch and address latch are never high together. The data output enable is low during read strobes.
- R10: Out of reset and while idle, request-ready is high, chip enable, write strobe and read strobe are high, and done is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle, request accepted when valid |
| req_row | input | 8*ROW_BYTES | Page row address |
| req_col | input | 16 | First column of the load |
| req_len | input | LEN_W | Total data bytes for the page |
| req_poll | input | 1 | 1: poll status, 0: watch ready/busy |
| din_valid | input | 1 | Data byte offered |
| din_ready | output | 1 | Data byte taken this cycle |
| din_data | input | 8 | Data byte |
| din_jump | input | 1 | Byte starts a new column segment |
| din_jump_col | input | 16 | Column of the new segment |
| done | output | 1 | One-cycle completion pulse |
| fail | output | 1 | Result, valid with done |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dq_o | output | 8 | Bus byte driven to device |
| nand_dq_oe | output | 1 | Bus output enable |
| nand_dq_i | input | 8 | Bus byte from device |
| nand_rb_n | input | 1 | Device ready (1) / busy (0) |

## Verification
A wrong address index or a stale jump flag appears at the very next write strobe as a byte or latch mismatch. The write-strobe scoreboard reports it within one bus cycle. A sequencer stuck in a wait state shows up as a missing done pulse. A bad status decode shows up as a wrong fail value or a wrong count of read strobes in the cycle after done. Reject handling and the ready/done handshake are visible one cycle after acceptance, through done, fail and chip enable.

// File: rtl/nps_pkg.sv
package nps_pkg;

  typedef enum logic [1:0] {
    BK_CMD,
    BK_ADDR,
    BK_WR,
    BK_RD
  } bus_kind_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_LOAD,
    ST_ADDR,
    ST_DATA,
    ST_JUMP,
    ST_JADDR,
    ST_CONFIRM,
    ST_WAIT_RB,
    ST_STAT_CMD,
    ST_STAT_RD,
    ST_GAP,
    ST_RESET,
    ST_FINISH
  } seq_state_e;

  localparam logic [7:0] CMD_LOAD    = 8'h80;
  localparam logic [7:0] CMD_JUMP    = 8'h85;
  localparam logic [7:0] CMD_CONFIRM = 8'h10;
  localparam logic [7:0] CMD_STATUS  = 8'h70;
  localparam logic [7:0] CMD_RESET   = 8'hFF;

  // address cycle idx: two column bytes, then row bytes low to high
  function automatic logic [7:0] addr_byte(input logic [15:0] col,
                                           input logic [31:0] row,
                                           input logic [2:0]  idx);
    logic [7:0] b;
    case (idx)
      3'd0:    b = col[7:0];
      3'd1:    b = col[15:8];
      3'd2:    b = row[7:0];
      3'd3:    b = row[15:8];
      3'd4:    b = row[23:16];
      default: b = row[31:24];
    endcase
    return b;
  endfunction

  function automatic logic len_ok(input int unsigned len, input int unsigned max_len);
    return (len != 0) && (len <= max_len);
  endfunction

  function automatic logic status_ready(input logic [7:0] st);
    return st[6];
  endfunction

  function automatic logic status_failed(input logic [7:0] st);
    return st[0];
  endfunction

endpackage

// File: rtl/nps_bus_phy.sv
module nps_bus_phy
  import nps_pkg::*;
#(
  parameter int PH_CYC = 2
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      start,
  input  bus_kind_e kind,
  input  logic [7:0] wbyte,
  input  logic [7:0] dq_i,
  output logic      done_o,
  output logic [7:0] rd_byte_o,
  output logic      cle,
  output logic      ale,
  output logic      we_n,
  output logic      re_n,
  output logic [7:0] dq_o,
  output logic      dq_oe
);
  localparam int CYC = 2 * PH_CYC;
  localparam int CW  = (CYC > 2) ? $clog2(CYC) : 1;
  localparam logic [CW-1:0] LAST    = CW'(CYC - 1);
  localparam logic [CW-1:0] LOW_END = CW'(PH_CYC - 1);

  logic          active_q;
  logic [CW-1:0] cnt_q;
  bus_kind_e     kind_q;
  logic [7:0]    byte_q;
  logic [7:0]    rd_q;
  logic          low_half;

  assign low_half = active_q && (cnt_q < CW'(PH_CYC));
  assign done_o   = active_q && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      kind_q   <= BK_CMD;
      byte_q   <= 8'h00;
      rd_q     <= 8'h00;
    end else begin
      if (start) begin
        active_q <= 1'b1;
        cnt_q    <= '0;
        kind_q   <= kind;
        byte_q   <= wbyte;
      end else if (active_q) begin
        if (cnt_q == LAST) active_q <= 1'b0;
        else               cnt_q    <= cnt_q + 1'b1;
      end
      if (active_q && kind_q == BK_RD && cnt_q == LOW_END) rd_q <= dq_i;
    end
  end

  assign rd_byte_o = rd_q;
  assign cle   = active_q && (kind_q == BK_CMD);
  assign ale   = active_q && (kind_q == BK_ADDR);
  assign we_n  = !(low_half && kind_q != BK_RD);
  assign re_n  = !(low_half && kind_q == BK_RD);
  assign dq_oe = active_q && (kind_q != BK_RD);
  assign dq_o  = byte_q;

endmodule

// File: rtl/nps_tick_timer.sv
module nps_tick_timer #(
  parameter int LIMIT = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  output logic hit
);
  localparam int TW = $clog2(LIMIT + 1);
  localparam logic [TW-1:0] TOP = TW'(LIMIT);

  logic [TW-1:0] cnt_q;

  assign hit = (cnt_q == TOP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= '0;
    else if (clr)        cnt_q <= '0;
    else if (en && !hit) cnt_q <= cnt_q + 1'b1;
  end

endmodule

// File: rtl/nand_prog_seq.sv
module nand_prog_seq
  import nps_pkg::*;
#(
  parameter int MAX_BYTES  = 2112,
  parameter int LEN_W      = 12,
  parameter int ROW_BYTES  = 3,
  parameter int PH_CYC     = 2,
  parameter int POLL_GAP   = 8,
  parameter int BUSY_LIMIT = 4096
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic [8*ROW_BYTES-1:0] req_row,
  input  logic [15:0]            req_col,
  input  logic [LEN_W-1:0]       req_len,
  input  logic                   req_poll,
  input  logic                   din_valid,
  output logic                   din_ready,
  input  logic [7:0]             din_data,
  input  logic                   din_jump,
  input  logic [15:0]            din_jump_col,
  output logic                   done,
  output logic                   fail,
  output logic                   nand_ce_n,
  output logic                   nand_cle,
  output logic                   nand_ale,
  output logic                   nand_we_n,
  output logic                   nand_re_n,
  output logic [7:0]             nand_dq_o,
  output logic                   nand_dq_oe,
  input  logic [7:0]             nand_dq_i,
  input  logic                   nand_rb_n
);
  localparam int ROW_W    = 8 * ROW_BYTES;
  localparam int ADDR_CYC = 2 + ROW_BYTES;
  localparam logic [2:0] ALAST = 3'(ADDR_CYC - 1);

  seq_state_e       state_q;
  logic             issued_q;
  logic [2:0]       aidx_q;
  logic [LEN_W-1:0] left_q;
  logic [ROW_W-1:0] row_q;
  logic [15:0]      col_q;
  logic             poll_q;
  logic             fail_q;
  logic             first_q;
  logic             jumped_q;

  logic       phy_start;
  bus_kind_e  phy_kind;
  logic [7:0] phy_byte;
  logic       phy_done;
  logic [7:0] phy_rd;

  logic busy_clr, busy_en, busy_hit;
  logic gap_clr, gap_en, gap_hit;

  // named events for the checker
  logic accept;
  logic len_bad;
  logic jump_req;
  logic timeout_evt;

  assign accept   = req_valid && req_ready;
  assign len_bad  = !len_ok(32'(req_len), MAX_BYTES);
  assign jump_req = din_valid && din_jump && !first_q && !jumped_q;

  assign busy_clr = (state_q == ST_CONFIRM) && phy_done;
  assign gap_clr  = busy_clr || ((state_q == ST_STAT_RD) && phy_done);
  assign busy_en  = (state_q == ST_WAIT_RB) || (state_q == ST_STAT_CMD) ||
                    (state_q == ST_STAT_RD) || (state_q == ST_GAP);
  assign gap_en   = (state_q == ST_WAIT_RB) || (state_q == ST_GAP);
  assign timeout_evt = busy_hit && ((state_q == ST_WAIT_RB) || (state_q == ST_GAP));

  always_comb begin
    phy_start = 1'b0;
    phy_kind  = BK_CMD;
    phy_byte  = 8'h00;
    din_ready = 1'b0;
    case (state_q)
      ST_LOAD: begin
        phy_start = !issued_q;
        phy_byte  = CMD_LOAD;
      end
      ST_ADDR: begin
        phy_start = !issued_q;
        phy_kind  = BK_ADDR;
        phy_byte  = addr_byte(col_q, 32'(row_q), aidx_q);
      end
      ST_DATA: begin
        phy_kind = BK_WR;
        phy_byte = din_data;
        if (!issued_q && din_valid && !jump_req) begin
          phy_start = 1'b1;
          din_ready = 1'b1;
        end
      end
      ST_JUMP: begin
        phy_start = !issued_q;
        phy_byte  = CMD_JUMP;
      end
      ST_JADDR: begin
        phy_start = !issued_q;
        phy_kind  = BK_ADDR;
        phy_byte  = aidx_q[0] ? col_q[15:8] : col_q[7:0];
      end
      ST_CONFIRM: begin
        phy_start = !issued_q;
        phy_byte  = CMD_CONFIRM;
      end
      ST_STAT_CMD: begin
        phy_start = !issued_q;
        phy_byte  = CMD_STATUS;
      end
      ST_STAT_RD: begin
        phy_start = !issued_q;
        phy_kind  = BK_RD;
      end
      ST_RESET: begin
        phy_start = !issued_q;
        phy_byte  = CMD_RESET;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      issued_q <= 1'b0;
      aidx_q   <= '0;
      left_q   <= '0;
      row_q    <= '0;
      col_q    <= '0;
      poll_q   <= 1'b0;
      fail_q   <= 1'b0;
      first_q  <= 1'b0;
      jumped_q <= 1'b0;
    end else begin
      if (phy_start) issued_q <= 1'b1;
      case (state_q)
        ST_IDLE: if (req_valid) begin
          row_q    <= req_row;
          col_q    <= req_col;
          left_q   <= req_len;
          poll_q   <= req_poll;
          first_q  <= 1'b1;
          jumped_q <= 1'b0;
          aidx_q   <= '0;
          issued_q <= 1'b0;
          fail_q   <= len_bad;
          state_q  <= len_bad ? ST_FINISH : ST_LOAD;
        end
        ST_LOAD: if (phy_done) begin
          issued_q <= 1'b0;
          aidx_q   <= '0;
          state_q  <= ST_ADDR;
        end
        ST_ADDR: if (phy_done) begin
          issued_q <= 1'b0;
          if (aidx_q == ALAST) state_q <= ST_DATA;
          else                 aidx_q  <= aidx_q + 1'b1;
        end
        ST_DATA: begin
          if (!issued_q && jump_req) begin
            col_q   <= din_jump_col;
            state_q <= ST_JUMP;
          end else if (phy_done) begin
            issued_q <= 1'b0;
            first_q  <= 1'b0;
            jumped_q <= 1'b0;
            left_q   <= left_q - 1'b1;
            if (left_q == LEN_W'(1)) state_q <= ST_CONFIRM;
          end
        end
        ST_JUMP: if (phy_done) begin
          issued_q <= 1'b0;
          aidx_q   <= '0;
          state_q  <= ST_JADDR;
        end
        ST_JADDR: if (phy_done) begin
          issued_q <= 1'b0;
          if (aidx_q[0]) begin
            jumped_q <= 1'b1;
            state_q  <= ST_DATA;
          end else begin
            aidx_q <= 3'd1;
          end
        end
        ST_CONFIRM: if (phy_done) begin
          issued_q <= 1'b0;
          state_q  <= poll_q ? ST_STAT_CMD : ST_WAIT_RB;
        end
        ST_WAIT_RB: begin
          if (timeout_evt)             state_q <= ST_RESET;
          else if (gap_hit && nand_rb_n) state_q <= ST_STAT_CMD;
        end
        ST_STAT_CMD: if (phy_done) begin
          issued_q <= 1'b0;
          state_q  <= ST_STAT_RD;
        end
        ST_STAT_RD: if (phy_done) begin
          issued_q <= 1'b0;
          if (status_ready(phy_rd)) begin
            fail_q  <= status_failed(phy_rd);
            state_q <= ST_FINISH;
          end else begin
            state_q <= ST_GAP;
          end
        end
        ST_GAP: begin
          if (timeout_evt)  state_q <= ST_RESET;
          else if (gap_hit) state_q <= ST_STAT_RD;
        end
        ST_RESET: if (phy_done) begin
          issued_q <= 1'b0;
          fail_q   <= 1'b1;
          state_q  <= ST_FINISH;
        end
        ST_FINISH: state_q <= ST_IDLE;
        default:   state_q <= ST_IDLE;
      endcase
    end
  end

  nps_bus_phy #(.PH_CYC(PH_CYC)) u_phy (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (phy_start),
    .kind     (phy_kind),
    .wbyte    (phy_byte),
    .dq_i     (nand_dq_i),
    .done_o   (phy_done),
    .rd_byte_o(phy_rd),
    .cle      (nand_cle),
    .ale      (nand_ale),
    .we_n     (nand_we_n),
    .re_n     (nand_re_n),
    .dq_o     (nand_dq_o),
    .dq_oe    (nand_dq_oe)
  );

  nps_tick_timer #(.LIMIT(BUSY_LIMIT)) u_busy_tmr (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (busy_clr),
    .en   (busy_en),
    .hit  (busy_hit)
  );

  nps_tick_timer #(.LIMIT(POLL_GAP)) u_gap_tmr (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (gap_clr),
    .en   (gap_en),
    .hit  (gap_hit)
  );

  assign req_ready = (state_q == ST_IDLE);
  assign done      = (state_q == ST_FINISH);
  assign fail      = fail_q;
  assign nand_ce_n = (state_q == ST_IDLE) || (state_q == ST_FINISH);

endmodule

// File: rtl/nand_prog_seq_chk.sv
module nand_prog_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_ready,
  input logic done,
  input logic fail,
  input logic nand_ce_n,
  input logic nand_cle,
  input logic nand_ale,
  input logic nand_we_n,
  input logic nand_re_n,
  input logic nand_dq_oe,
  input logic len_bad,
  input logic timeout_evt
);

  // R3
  reject_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && len_bad) |=> (done && fail));

  // R8
  accept_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  // R8
  ready_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_ready) |-> $past(done));

  // R9
  latch_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nand_cle |-> !nand_ale);

  // R9
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !nand_we_n |-> nand_re_n);

  // R9
  read_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !nand_re_n |-> !nand_dq_oe);

  // R10
  idle_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (nand_ce_n && nand_we_n && nand_re_n && !done));

  // R7
  timeout_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_evt |-> !nand_ce_n);

endmodule

bind nand_prog_seq nand_prog_seq_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .done       (done),
  .fail       (fail),
  .nand_ce_n  (nand_ce_n),
  .nand_cle   (nand_cle),
  .nand_ale   (nand_ale),
  .nand_we_n  (nand_we_n),
  .nand_re_n  (nand_re_n),
  .nand_dq_oe (nand_dq_oe),
  .len_bad    (len_bad),
  .timeout_evt(timeout_evt)
);

// File: tb/nand_prog_seq_tb.sv
module nand_prog_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int PH    = 2;
  localparam int GAP   = 8;
  localparam int LIMIT = 400;
  localparam int MAXB  = 2112;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [23:0] req_row = '0;
  logic [15:0] req_col = '0;
  logic [11:0] req_len = '0;
  logic        req_poll = 1'b0;
  logic        din_valid = 1'b0;
  logic        din_ready;
  logic [7:0]  din_data = '0;
  logic        din_jump = 1'b0;
  logic [15:0] din_jump_col = '0;
  logic        done, fail;
  logic        nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe;
  logic [7:0]  nand_dq_o, nand_dq_i;
  logic        nand_rb_n;

  always #(CLK_PERIOD/2) clk = ~clk;

  nand_prog_seq #(
    .MAX_BYTES(MAXB), .LEN_W(12), .ROW_BYTES(3),
    .PH_CYC(PH), .POLL_GAP(GAP), .BUSY_LIMIT(LIMIT)
  ) u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_row(req_row), .req_col(req_col), .req_len(req_len), .req_poll(req_poll),
    .din_valid(din_valid), .din_ready(din_ready), .din_data(din_data),
    .din_jump(din_jump), .din_jump_col(din_jump_col),
    .done(done), .fail(fail),
    .nand_ce_n(nand_ce_n), .nand_cle(nand_cle), .nand_ale(nand_ale),
    .nand_we_n(nand_we_n), .nand_re_n(nand_re_n),
    .nand_dq_o(nand_dq_o), .nand_dq_oe(nand_dq_oe),
    .nand_dq_i(nand_dq_i), .nand_rb_n(nand_rb_n)
  );

  int checks = 0;
  int failures = 0;
  string cur_tag = "R1";

  // scoreboard items: {kind[1:0], byte}; kind 1=command 2=address 3=data
  logic [9:0] exp_q[$];

  // device model configuration (driven by the driver only)
  int busy_len = 0;
  bit hang_cfg = 1'b0;
  bit fail_cfg = 1'b0;

  // device model state (driven by the monitor only)
  int busy_m = 0;
  bit hang_m = 1'b0;
  bit rb_m = 1'b1;
  int reads = 0;
  int ce_low = 0;
  int done_cnt = 0;
  bit last_fail = 1'b0;
  int width_bad = 0;
  int we_low = 0, re_low = 0;
  bit prev_we = 1'b1, prev_re = 1'b1;

  assign nand_rb_n = rb_m;
  assign nand_dq_i = {1'b0, rb_m, 5'b0, fail_cfg & rb_m};

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, expv);
    end
  endtask

  function automatic logic [7:0] dval(input int i, input int seed);
    return 8'(i * 13 + seed);
  endfunction

  function automatic logic [15:0] jcol(input int i);
    return 16'(16'h0200 + i * 5);
  endfunction

  // monitor: pops expected bus writes and models the device
  always @(negedge clk) begin
    if (rst_n) begin
      if (!nand_ce_n) ce_low++;
      if (!nand_we_n) we_low++;
      if (!nand_re_n) re_low++;
      if (nand_we_n && !prev_we) begin
        logic [9:0] ev;
        logic [9:0] e;
        if (we_low != PH) width_bad++;
        we_low = 0;
        ev = {(nand_cle ? 2'd1 : (nand_ale ? 2'd2 : 2'd3)), nand_dq_o};
        if (exp_q.size() == 0) begin
          check(1'b0, cur_tag, "unexpected bus write", int'(ev), 0);
        end else begin
          e = exp_q.pop_front();
          check(ev == e, cur_tag, "bus write", int'(ev), int'(e));
        end
        if (nand_cle && nand_dq_o == 8'h10) begin
          rb_m = 1'b0;
          hang_m = hang_cfg;
          busy_m = busy_len;
        end
        if (nand_cle && nand_dq_o == 8'hFF) begin
          hang_m = 1'b0;
          busy_m = 0;
          rb_m = 1'b1;
        end
      end
      if (nand_re_n && !prev_re) begin
        if (re_low != PH) width_bad++;
        re_low = 0;
        reads++;
      end
      if (!hang_m && busy_m > 0) begin
        busy_m--;
        if (busy_m == 0) rb_m = 1'b1;
      end
      prev_we = nand_we_n;
      prev_re = nand_re_n;
      if (done) begin
        done_cnt++;
        last_fail = fail;
        check(!req_ready, "R8", "ready during done", int'(req_ready), 0);
      end
    end
  end

  // driver: queues the expected bus writes, then drives request and data
  task automatic run(input string tag, input bit poll, input logic [23:0] row,
                     input logic [15:0] col, input int len, input int busy,
                     input bit hang, input bit finj, input int ja, input int jb,
                     input bit j0, input int seed);
    int d0, r0, c0;
    bit reject;
    bit exp_fail;
    reject = (len == 0) || (len > MAXB);
    exp_fail = reject || hang || finj;
    cur_tag = tag;
    busy_len = busy;
    hang_cfg = hang;
    fail_cfg = finj;
    if (!reject) begin
      exp_q.push_back({2'd1, 8'h80});
      exp_q.push_back({2'd2, col[7:0]});
      exp_q.push_back({2'd2, col[15:8]});
      exp_q.push_back({2'd2, row[7:0]});
      exp_q.push_back({2'd2, row[15:8]});
      exp_q.push_back({2'd2, row[23:16]});
      for (int i = 0; i < len; i++) begin
        if (i != 0 && (i == ja || i == jb)) begin
          logic [15:0] c;
          c = jcol(i);
          exp_q.push_back({2'd1, 8'h85});
          exp_q.push_back({2'd2, c[7:0]});
          exp_q.push_back({2'd2, c[15:8]});
        end
        exp_q.push_back({2'd3, dval(i, seed)});
      end
      exp_q.push_back({2'd1, 8'h10});
      if (poll || !hang) exp_q.push_back({2'd1, 8'h70});
      if (hang) exp_q.push_back({2'd1, 8'hFF});
    end
    d0 = done_cnt;
    r0 = reads;
    c0 = ce_low;
    @(negedge clk);
    req_row = row;
    req_col = col;
    req_len = 12'(len);
    req_poll = poll;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check(!req_ready, "R8", "ready after accept", int'(req_ready), 0);
    if (reject) begin
      check(done && fail, "R3", "reject done/fail next cycle", int'({done, fail}), 3);
    end else begin
      for (int i = 0; i < len; i++) begin
        din_valid = 1'b1;
        din_data = dval(i, seed);
        din_jump = (i == ja || i == jb || (i == 0 && j0));
        din_jump_col = jcol(i);
        #1;
        while (!din_ready) begin
          @(negedge clk);
          #1;
        end
        @(posedge clk);
        @(negedge clk);
      end
      din_valid = 1'b0;
      din_jump = 1'b0;
    end
    while (done_cnt == d0) @(negedge clk);
    @(negedge clk);
    check(last_fail == exp_fail, tag, "fail flag", int'(last_fail), int'(exp_fail));
    check(exp_q.size() == 0, tag, "missing bus writes", exp_q.size(), 0);
    check(req_ready, "R8", "ready after done", int'(req_ready), 1);
    if (reject) check(ce_low == c0, "R3", "chip enable touched", ce_low - c0, 0);
    else if (!poll && !hang) check(reads - r0 == 1, "R4", "status reads", reads - r0, 1);
    else if (poll && !hang) check(reads - r0 >= 2, "R5", "repeated status reads", reads - r0, 2);
    exp_q.delete();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    check(req_ready, "R10", "ready in reset", int'(req_ready), 1);
    check(nand_ce_n && nand_we_n && nand_re_n, "R10", "bus idle in reset",
          int'({nand_ce_n, nand_we_n, nand_re_n}), 7);
    check(!done, "R10", "done in reset", int'(done), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(req_ready && nand_ce_n && !done, "R10", "idle after reset",
          int'({req_ready, nand_ce_n, done}), 6);

    // R1 R5 R6: plain load, status polling, pass
    run("R1", 1'b1, 24'h0A0B0C, 16'h0123, 4, 60, 1'b0, 1'b0, -1, -1, 1'b0, 5);
    // R2 R4 R6: two column jumps plus ignored flag on first byte, ready/busy wait, fail
    run("R2", 1'b0, 24'h123456, 16'h0040, 6, 40, 1'b0, 1'b1, 2, 4, 1'b1, 9);
    // R6: polling with failing status
    run("R6", 1'b1, 24'h00FF01, 16'h0800, 3, 30, 1'b0, 1'b1, -1, -1, 1'b0, 77);
    // R3: zero count and oversize count
    run("R3", 1'b1, 24'h000001, 16'h0000, 0, 10, 1'b0, 1'b0, -1, -1, 1'b0, 1);
    run("R3", 1'b0, 24'h000002, 16'h0000, MAXB + 1, 10, 1'b0, 1'b0, -1, -1, 1'b0, 1);
    // R7: busy never ends, both completion modes
    run("R7", 1'b1, 24'h777777, 16'h0010, 2, 0, 1'b1, 1'b0, -1, -1, 1'b0, 3);
    run("R7", 1'b0, 24'h888888, 16'h0020, 2, 0, 1'b1, 1'b0, 1, -1, 1'b0, 4);
    // R1 R4: full page at the size limit, ready/busy wait
    run("R1", 1'b0, 24'h010203, 16'h0000, MAXB, 30, 1'b0, 1'b0, 100, -1, 1'b0, 11);
    // R5 after a timeout the next request is served normally
    run("R5", 1'b1, 24'h0F0E0D, 16'h0002, 1, 25, 1'b0, 1'b0, -1, -1, 1'b0, 21);

    // R9 strobe widths seen across all bus cycles
    check(width_bad == 0, "R9", "strobe low width errors", width_bad, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule